// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a three-wire serial audio stream (bit clock, word select and serial data) into parallel stereo samples. It runs directly on the incoming bit clock. Data is sampled on the rising edge. Word-select transitions are found by comparing the current word-select level with the level seen on the previous bit clock. In every sample period it recovers one left and one right word. It then presents the pair on two parallel outputs together with a one-cycle valid strobe.

A static two-bit format input chooses the framing: right-justified 16-bit, right-justified 18-bit, left-justified 16-bit, or I2S 16-bit. A second static input gives the bit-clock ratio, 64 or 32 bit clocks per sample period. The ratio matters only for I2S, where the last data bit of a 32fs slot spills into the next slot. Every sample arrives MSB first.

The output width is fixed at 18 bits. A 16-bit sample is placed in the upper 16 bits and the two low bits are zero. Clock generation, master-clock recovery, filtering, volume control and the converter itself belong to other blocks.

Top module: `aud_serial_rx`

## Requirements
- R1: With fmt=0 (right-justified 16-bit, 32-bit slots), the sample is the last 16 bits of each slot, MSB first. Earlier bits in the slot have no effect. The sample appears on the output as {sample, 2'b00}.
- R2: With fmt=1 (right-justified 18-bit, 32-bit slots), the sample is the last 18 bits of each slot and appears unchanged on the 18-bit output. Earlier bits in the slot have no effect.
- R3: With fmt=2 (left-justified 16-bit), the MSB is the bit sampled at the first rising bit-clock edge that sees the new word-select level. The next 15 bits complete the sample and later bits in the slot are ignored. This works with either bit-clock ratio and the output is {sample, 2'b00}.
- R4: With fmt=3 (I2S 16-bit) and bclk_x64=1, the MSB is the second bit of the slot. Bits 1 to 16 form the sample, and bit 0 and bits 17 to 31 are ignored. The output is {sample, 2'b00}.
- R5: With fmt=3 and bclk_x64=0 (16-bit slots), bits 1 to 15 of a slot carry sample bits 15 to 1. The LSB is bit 0 of the following slot.
- R6: In I2S the left channel is the word-select-low slot. In the three justified formats the left channel is the word-select-high slot.
- R7: After the right word of a period is captured, left_o and right_o are loaded together and valid_o is high for exactly one bit-clock cycle. A pair needs a left word captured since the previous pair. The outputs hold their values between pulses.
- R8: While rst_n is low, left_o and right_o are zero and valid_o is low. After reset no word is captured until the first word-select transition has been seen, and no valid_o pulse occurs before a left word has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt | input | 2 | Framing select: 0 RJ16, 1 RJ18, 2 LJ16, 3 I2S16 (static) |
| bclk_x64 | input | 1 | 1: 64 bit clocks per sample period, 0: 32 (static) |
| ws | input | 1 | Word select (left/right clock) |
| sd | input | 1 | Serial data, MSB first |
| left_o | output | 18 | Recovered left sample, 16-bit formats left-aligned |
| right_o | output | 18 | Recovered right sample, 16-bit formats left-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
There are three ways the internal state can go wrong, and each shows up at the ports. A bit-position counter that is one off shifts every word by one place, so the recovered value is doubled or halved with a stray bit. This is visible at the first valid_o of the period. A wrong channel-polarity or pairing flag swaps left_o and right_o, or drops or repeats a pulse, within one sample period. A capture point that fires before the first word-select transition gives a pulse during the lead-in, before any expected pair.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      FMT_RJ16  = 2'd0,
      FMT_RJ18  = 2'd1,
      FMT_LJ16  = 2'd2,
      FMT_I2S16 = 2'd3
   } frame_fmt_e;

endpackage

// File: rtl/aud_rx_slot_track.sv
module aud_rx_slot_track #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ws,
   output logic             ws_flip,
   output logic [CNT_W-1:0] bit_idx,
   output logic             slot_ws,
   output logic             prev_ws,
   output logic             synced
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2) begin : g_chk_cnt
      $error("aud_rx_slot_track: CNT_W too small");
   end

   logic             ws_q;
   logic             primed_q;
   logic             synced_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   // a flip is only meaningful once one level has been sampled
   assign ws_flip = primed_q && (ws != ws_q);

   always_comb begin
      if (ws_flip)
         cnt_d = '0;
      else if (cnt_q == CNT_MAX)
         cnt_d = CNT_MAX;
      else
         cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_q     <= 1'b0;
         primed_q <= 1'b0;
         synced_q <= 1'b0;
         cnt_q    <= CNT_MAX;
      end else begin
         ws_q     <= ws;
         primed_q <= 1'b1;
         synced_q <= synced_q | ws_flip;
         cnt_q    <= cnt_d;
      end
   end

   assign bit_idx = cnt_d;
   assign slot_ws = ws;
   assign prev_ws = ws_q;
   assign synced  = synced_q;

endmodule

// File: rtl/aud_rx_word_cap.sv
module aud_rx_word_cap
   import aud_rx_pkg::*;
#(
   parameter int LONG_W  = 18,
   parameter int SHORT_W = 16,
   parameter int CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  frame_fmt_e        fmt,
   input  logic              x64,
   input  logic              sd,
   input  logic              ws_flip,
   input  logic [CNT_W-1:0]  bit_idx,
   input  logic              slot_ws,
   input  logic              prev_ws,
   input  logic              synced,
   output logic              cap_stb,
   output logic [LONG_W-1:0] cap_word,
   output logic              cap_left
);

   localparam logic [CNT_W-1:0] LJ_LAST  = CNT_W'(SHORT_W - 1);
   localparam logic [CNT_W-1:0] I2S_LAST = CNT_W'(SHORT_W);

   if (SHORT_W > LONG_W) begin : g_chk_w
      $error("aud_rx_word_cap: SHORT_W exceeds LONG_W");
   end
   if ((2 ** CNT_W) <= SHORT_W) begin : g_chk_cnt
      $error("aud_rx_word_cap: counter cannot reach the I2S LSB");
   end

   logic [LONG_W-1:0] sh_q;
   logic [LONG_W-1:0] sh_n;
   logic [LONG_W-1:0] pad_old;
   logic [LONG_W-1:0] pad_new;
   logic              ch_ws;

   assign sh_n = {sh_q[LONG_W-2:0], sd};

   // short words are left-aligned into the long output word
   if (LONG_W > SHORT_W) begin : g_pad
      assign pad_old = {sh_q[SHORT_W-1:0], {(LONG_W-SHORT_W){1'b0}}};
      assign pad_new = {sh_n[SHORT_W-1:0], {(LONG_W-SHORT_W){1'b0}}};
   end else begin : g_nopad
      assign pad_old = sh_q;
      assign pad_new = sh_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_n;
   end

   always_comb begin
      cap_stb  = 1'b0;
      cap_word = pad_new;
      ch_ws    = slot_ws;
      unique case (fmt)
         FMT_RJ16: begin
            // word ended on the bit before the flip
            cap_stb  = synced && ws_flip;
            cap_word = pad_old;
            ch_ws    = prev_ws;
         end
         FMT_RJ18: begin
            cap_stb  = synced && ws_flip;
            cap_word = sh_q;
            ch_ws    = prev_ws;
         end
         FMT_LJ16: begin
            cap_stb  = synced && (bit_idx == LJ_LAST);
            cap_word = pad_new;
            ch_ws    = slot_ws;
         end
         FMT_I2S16: begin
            if (x64) begin
               cap_stb = synced && (bit_idx == I2S_LAST);
               ch_ws   = slot_ws;
            end else begin
               // LSB is bit 0 of the next slot
               cap_stb = synced && ws_flip;
               ch_ws   = prev_ws;
            end
            cap_word = pad_new;
         end
         default: cap_stb = 1'b0;
      endcase
   end

   assign cap_left = (fmt == FMT_I2S16) ? ~ch_ws : ch_ws;

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
   parameter int LONG_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_stb,
   input  logic [LONG_W-1:0] cap_word,
   input  logic              cap_left,
   output logic [LONG_W-1:0] left_o,
   output logic [LONG_W-1:0] right_o,
   output logic              valid_o
);

   logic [LONG_W-1:0] hold_q;
   logic              seen_q;
   logic              emit;

   assign emit = cap_stb && !cap_left && seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         seen_q  <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= emit;
         if (cap_stb && cap_left) begin
            hold_q <= cap_word;
            seen_q <= 1'b1;
         end else if (emit) begin
            seen_q <= 1'b0;
         end
         if (emit) begin
            left_o  <= hold_q;
            right_o <= cap_word;
         end
      end
   end

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int LONG_W   = 18,
   parameter int SHORT_W  = 16,
   parameter int SLOT_MAX = 32
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic [1:0]        fmt,
   input  logic              bclk_x64,
   input  logic              ws,
   input  logic              sd,
   output logic [LONG_W-1:0] left_o,
   output logic [LONG_W-1:0] right_o,
   output logic              valid_o
);

   localparam int CNT_W = $clog2(SLOT_MAX) + 1;

   if (SLOT_MAX < LONG_W) begin : g_chk_slot
      $error("aud_serial_rx: slot shorter than the long word");
   end

   frame_fmt_e        fmt_e;
   logic              ws_flip;
   logic [CNT_W-1:0]  bit_idx;
   logic              slot_ws;
   logic              prev_ws;
   logic              synced;
   logic              cap_stb;
   logic [LONG_W-1:0] cap_word;
   logic              cap_left;

   assign fmt_e = frame_fmt_e'(fmt);

   aud_rx_slot_track #(.CNT_W(CNT_W)) u_track (
      .clk     (bclk),
      .rst_n   (rst_n),
      .ws      (ws),
      .ws_flip (ws_flip),
      .bit_idx (bit_idx),
      .slot_ws (slot_ws),
      .prev_ws (prev_ws),
      .synced  (synced)
   );

   aud_rx_word_cap #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_cap (
      .clk      (bclk),
      .rst_n    (rst_n),
      .fmt      (fmt_e),
      .x64      (bclk_x64),
      .sd       (sd),
      .ws_flip  (ws_flip),
      .bit_idx  (bit_idx),
      .slot_ws  (slot_ws),
      .prev_ws  (prev_ws),
      .synced   (synced),
      .cap_stb  (cap_stb),
      .cap_word (cap_word),
      .cap_left (cap_left)
   );

   aud_rx_pair #(.LONG_W(LONG_W)) u_pair (
      .clk      (bclk),
      .rst_n    (rst_n),
      .cap_stb  (cap_stb),
      .cap_word (cap_word),
      .cap_left (cap_left),
      .left_o   (left_o),
      .right_o  (right_o),
      .valid_o  (valid_o)
   );

   assert_valid_after_sync_R8: assert property (@(posedge bclk) disable iff (!rst_n)
      valid_o |-> synced);

   assert_short_pad_R1: assert property (@(posedge bclk) disable iff (!rst_n)
      (valid_o && fmt_e != FMT_RJ18) |->
         (left_o[LONG_W-SHORT_W-1:0] == '0 && right_o[LONG_W-SHORT_W-1:0] == '0));

endmodule

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt = 2'd0;
   logic        bclk_x64 = 1'b1;
   logic        ws = 1'b0;
   logic        sd = 1'b0;
   logic [17:0] left_o;
   logic [17:0] right_o;
   logic        valid_o;

   int n_chk = 0;
   int n_fail = 0;
   int n_valid = 0;
   logic [35:0] exp_q[$];
   string cur_tag = "R8";
   logic prev_valid = 1'b0;

   always #2 bclk = ~bclk;

   aud_serial_rx dut (
      .bclk(bclk), .rst_n(rst_n), .fmt(fmt), .bclk_x64(bclk_x64),
      .ws(ws), .sd(sd), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                      input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge bclk) begin
      if (rst_n) begin
         if (valid_o && prev_valid)
            chk(1'b0, "R7 valid longer than one cycle", 36'd1, 36'd0);
         if (valid_o) begin
            n_valid++;
            if (exp_q.size() == 0) begin
               chk(1'b0, {"R8 unexpected pair ", cur_tag}, {left_o, right_o}, 36'd0);
            end else begin
               logic [35:0] e;
               e = exp_q.pop_front();
               chk({left_o, right_o} == e, cur_tag, {left_o, right_o}, e);
            end
         end
      end
      prev_valid = valid_o;
   end

   function automatic logic [31:0] junk(input int seed);
      return (32'(seed) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
   endfunction

   function automatic logic [31:0] build_slot(input int f, input bit x64,
         input logic [17:0] cur, input logic prev_lsb, input logic [31:0] j);
      logic [31:0] s;
      s = j;
      case (f)
         0: s[15:0]  = cur[15:0];
         1: s[17:0]  = cur;
         2: s[31:16] = cur[15:0];
         default: begin
            if (x64) s[30:15] = cur[15:0];
            else begin
               s[31]    = prev_lsb;
               s[30:16] = cur[15:1];
            end
         end
      endcase
      return s;
   endfunction

   task automatic send_slot(input logic lvl, input logic [31:0] s, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge bclk);
         ws = lvl;
         sd = s[31-i];
      end
   endtask

   function automatic logic [17:0] gen_word(input int run, input int k, input int ch);
      case (k)
         0: return ch ? 18'h00000 : 18'h3FFFF;
         1: return ch ? 18'h15555 : 18'h2AAAA;
         2: return ch ? 18'h17FFF : 18'h28000;
         default: return 18'((k * 18'h2B3C7) ^ (run * 18'h01F00) ^ (ch * 18'h0A5A5));
      endcase
   endfunction

   task automatic run_mode(input int f, input bit x64, input int run, input string tag);
      int len;
      logic lvl_l, lvl_r, prev_lsb;
      logic [17:0] wl, wr;
      logic [35:0] e;
      len = x64 ? 32 : 16;
      lvl_l = (f == 3) ? 1'b0 : 1'b1;
      lvl_r = ~lvl_l;
      // reset with ws parked at the lead-in level
      @(negedge bclk);
      rst_n = 1'b0;
      fmt = 2'(f);
      bclk_x64 = x64;
      ws = lvl_r;
      sd = 1'b1;
      cur_tag = tag;
      repeat (3) @(negedge bclk);
      chk(left_o == 18'd0 && right_o == 18'd0 && valid_o == 1'b0,
          "R8 reset state", {left_o, right_o}, 36'd0);
      n_valid = 0;
      rst_n = 1'b1;
      // lead-in slot of junk on the right level
      send_slot(lvl_r, junk(run * 7 + 1), len);
      prev_lsb = 1'b1;
      for (int k = 0; k < 6; k++) begin
         wl = gen_word(run, k, 0);
         wr = gen_word(run, k, 1);
         if (f == 1) e = {wl, wr};
         else        e = {wl[15:0], 2'b00, wr[15:0], 2'b00};
         exp_q.push_back(e);
         send_slot(lvl_l, build_slot(f, x64, wl, prev_lsb, junk(run * 31 + k * 2)), len);
         if (k == 0)
            chk(n_valid == 0, "R8 no pair before first left word", 36'(n_valid), 36'd0);
         prev_lsb = wl[0];
         send_slot(lvl_r, build_slot(f, x64, wr, prev_lsb, junk(run * 31 + k * 2 + 1)), len);
         prev_lsb = wr[0];
      end
      // trailing slot closes the last right word, then idle on one level
      send_slot(lvl_l, build_slot(f, x64, 18'h0F0F0, prev_lsb, junk(run + 99)), len);
      send_slot(lvl_l, junk(run + 77), 32);
      send_slot(lvl_l, junk(run + 55), 32);
      chk(exp_q.size() == 0, {"R7 missing pairs ", tag}, 36'(exp_q.size()), 36'd0);
      chk(n_valid == 6, {"R7 pair count ", tag}, 36'(n_valid), 36'd6);
      exp_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge bclk);
      n_fail++;
      $display("FAIL R7 watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      run_mode(0, 1'b1, 1, "R1 R6 R7 right-justified 16");
      run_mode(1, 1'b1, 2, "R2 R6 R7 right-justified 18");
      run_mode(2, 1'b1, 3, "R3 R6 R7 left-justified 64fs");
      run_mode(2, 1'b0, 4, "R3 R6 R7 left-justified 32fs");
      run_mode(3, 1'b1, 5, "R4 R6 R7 i2s 64fs");
      run_mode(3, 1'b0, 6, "R5 R6 R7 i2s 32fs");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule